// File: doc/BRIEF.md
# Privileged Thread-ID Register Access Gate

The block holds one 64-bit thread-identification word that belongs to the hypervisor privilege level. It also holds the decision logic that settles what becomes of every read or write aimed at that word. A request carries a five-field system register encoding, the requester's privilege level (0 to 3), a flag saying whether level 2 is enabled, two nested-virtualization control bits (`req_nv` and `req_nv2`) and 64 bits of write data.

For each request whose encoding selects this register, the block reports exactly one of four outcomes, one cycle later:

- an undefined-instruction indication;
- a trap to level 2, with a 6-bit exception class;
- a redirect of the access to a memory slot at a fixed 12-bit offset;
- a direct read or write of the register.

For a redirected read, the block returns the slot data that the surrounding logic presents. For a redirected write, it hands the write data out so the surrounding logic can store it. The block only reports these outcomes. It does not issue memory transactions and it does not perform exception entry.

A second, 32-bit port views the low half of the same storage as a legacy alias. The parameter `HAS_L2` builds a variant with no level 2. In that variant the register reads as zero from level 3 and ignores every write.

Top module: `tid_gate`

## Requirements
- R1: A request acts only when its encoding is op0=2'b11, op1=3'b100, CRn=4'b1101, CRm=4'b0000, op2=3'b010, for reads and writes alike. Any other encoding raises no outcome and leaves the register unchanged.
- R2: A matching request at privilege level 0 raises `rsp_undef`.
- R3: A matching request at level 1, with level 2 enabled and both `req_nv` and `req_nv2` set, raises `rsp_redir` with `rsp_redir_off` = 12'h090. A read returns `mem_rdata` (sampled with the request) on `rsp_rdata`. A write raises `rsp_mem_we` with `rsp_mem_wdata` equal to the write data. The register is not touched.
- R4: A matching request at level 1, with level 2 enabled, `req_nv`=1 and `req_nv2`=0, raises `rsp_trap` with `rsp_trap_ec` = 6'h18.
- R5: A matching request at level 1 in every other case raises `rsp_undef`.
- R6: A matching request at level 2 or 3 raises `rsp_direct`. A read returns the full 64-bit register on `rsp_rdata`. A write replaces all 64 bits.
- R7: The outcome flags `rsp_undef`, `rsp_trap`, `rsp_redir` and `rsp_direct` are registered. They appear in the cycle after the request, hold for that one cycle, and at most one is high. All of them are low after reset and in cycles that follow no request.
- R8: A direct write takes effect on the clock edge that samples it. Its own response carries the value held before the write on `rsp_rdata`.
- R9: `al_rdata` always shows register bits [31:0]. An alias write with `al_level` of 2 or 3 replaces bits [31:0] and keeps bits [63:32]. An alias write at level 0 or 1 is ignored. When a direct write and an alias write coincide, the direct write wins.
- R10: With `HAS_L2`=0, the register reads as zero through both views and ignores all writes. A matching request at level 3 raises `rsp_direct` with zero data. A matching request at levels 0 to 2 raises `rsp_undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the response stage |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_level | input | 2 | Requester privilege level |
| req_l2_en | input | 1 | Level 2 enabled in the current security state |
| req_nv | input | 1 | Nested-virtualization trap control |
| req_nv2 | input | 1 | Nested-virtualization redirect control |
| req_wdata | input | 64 | Write data |
| mem_rdata | input | 64 | Contents of the redirect slot |
| al_wr_en | input | 1 | Alias write request |
| al_level | input | 2 | Privilege level of the alias writer |
| al_wdata | input | 32 | Alias write data |
| al_rdata | output | 32 | Alias view of bits [31:0] |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_trap | output | 1 | Trap-to-level-2 outcome |
| rsp_trap_ec | output | 6 | Exception class of the trap |
| rsp_redir | output | 1 | Memory-redirect outcome |
| rsp_redir_off | output | 12 | Slot offset of the redirect |
| rsp_direct | output | 1 | Direct register access outcome |
| rsp_rdata | output | 64 | Read data of a direct or redirected access |
| rsp_mem_we | output | 1 | Redirected write strobe |
| rsp_mem_wdata | output | 64 | Redirected write data |

## Verification
The bench builds two copies side by side and drives the same inputs into both. One copy uses the default parameters (level 2 present). The other sets `HAS_L2`=0. The default copy reaches the full outcome table across every level and control-bit mix. It also covers the old-value return on a direct write and the conflict between the alias port and the main port. The second copy shows the read-as-zero, write-ignored behaviour and the collapse of levels 1 and 2 to the undefined outcome when level 2 does not exist.

// File: rtl/tid_gate_pkg.sv
package tid_gate_pkg;

    typedef enum logic [1:0] {
        OUT_UNDEF  = 2'd0,
        OUT_TRAP   = 2'd1,
        OUT_REDIR  = 2'd2,
        OUT_DIRECT = 2'd3
    } outcome_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam sysenc_t TID_ENC = '{op0: 2'b11, op1: 3'b100, crn: 4'b1101,
                                   crm: 4'b0000, op2: 3'b010};

    localparam logic [1:0] LVL_USER = 2'd0;
    localparam logic [1:0] LVL_KERN = 2'd1;
    localparam logic [1:0] LVL_HYP  = 2'd2;
    localparam logic [1:0] LVL_MON  = 2'd3;

endpackage

// File: rtl/tid_gate_decode.sv
module tid_gate_decode
    import tid_gate_pkg::*;
#(
    parameter int HAS_L2 = 1
) (
    input  sysenc_t    enc,
    input  logic [1:0] level,
    input  logic       l2_en,
    input  logic       nv,
    input  logic       nv2,
    output logic       hit,
    output outcome_e   outcome
);
    localparam bit L2_ON = (HAS_L2 != 0);

    logic l2_live;

    always_comb begin
        hit     = (enc == TID_ENC);
        l2_live = L2_ON && l2_en;
        outcome = OUT_UNDEF;
        unique case (level)
            LVL_USER: outcome = OUT_UNDEF;
            LVL_KERN: begin
                if (l2_live && nv && nv2) begin
                    outcome = OUT_REDIR;
                end else if (l2_live && nv) begin
                    outcome = OUT_TRAP;
                end else begin
                    outcome = OUT_UNDEF;
                end
            end
            LVL_HYP:  outcome = L2_ON ? OUT_DIRECT : OUT_UNDEF;
            LVL_MON:  outcome = OUT_DIRECT;
            default:  outcome = OUT_UNDEF;
        endcase
    end

endmodule

// File: rtl/tid_gate_store.sv
module tid_gate_store #(
    parameter int DATA_W  = 64,
    parameter int ALIAS_W = 32,
    parameter int HAS_L2  = 1
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               al_wr_en,
    input  logic [ALIAS_W-1:0] al_wr_data,
    output logic [DATA_W-1:0]  value
);
    generate
        if (HAS_L2 != 0) begin : g_store
            logic [DATA_W-1:0] val_d;
            logic [DATA_W-1:0] val_q;

            always_comb begin
                val_d = val_q;
                if (wr_en) begin
                    val_d = wr_data;
                end else if (al_wr_en) begin
                    val_d[ALIAS_W-1:0] = al_wr_data;
                end
            end

            // Contents are undefined after a warm reset, so no reset term.
            always_ff @(posedge clk) begin
                val_q <= val_d;
            end

            assign value = val_q;
        end else begin : g_absent
            logic unused_ins;
            assign unused_ins = ^{clk, wr_en, wr_data, al_wr_en, al_wr_data};
            assign value      = '0;
        end
    endgenerate

endmodule

// File: rtl/tid_gate.sv
module tid_gate
    import tid_gate_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                ALIAS_W   = 32,
    parameter int                EC_W      = 6,
    parameter int                OFF_W     = 12,
    parameter logic [EC_W-1:0]   TRAP_EC   = 6'h18,
    parameter logic [OFF_W-1:0]  REDIR_OFF = 12'h090,
    parameter int                HAS_L2    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_op0,
    input  logic [2:0]         req_op1,
    input  logic [3:0]         req_crn,
    input  logic [3:0]         req_crm,
    input  logic [2:0]         req_op2,
    input  logic [1:0]         req_level,
    input  logic               req_l2_en,
    input  logic               req_nv,
    input  logic               req_nv2,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               al_wr_en,
    input  logic [1:0]         al_level,
    input  logic [ALIAS_W-1:0] al_wdata,
    output logic [ALIAS_W-1:0] al_rdata,
    output logic               rsp_undef,
    output logic               rsp_trap,
    output logic [EC_W-1:0]    rsp_trap_ec,
    output logic               rsp_redir,
    output logic [OFF_W-1:0]   rsp_redir_off,
    output logic               rsp_direct,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_mem_we,
    output logic [DATA_W-1:0]  rsp_mem_wdata
);
    localparam bit L2_ON = (HAS_L2 != 0);

    typedef struct packed {
        logic              undef;
        logic              trap;
        logic [EC_W-1:0]   ec;
        logic              redir;
        logic [OFF_W-1:0]  off;
        logic              direct;
        logic [DATA_W-1:0] rdata;
        logic              mem_we;
        logic [DATA_W-1:0] mem_wdata;
    } rsp_t;

    sysenc_t           enc;
    logic              hit;
    outcome_e          outcome;
    logic [DATA_W-1:0] value;
    logic              dir_wr;
    logic              al_ok;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn,
                   crm: req_crm, op2: req_op2};

    tid_gate_decode #(
        .HAS_L2 (HAS_L2)
    ) u_decode (
        .enc     (enc),
        .level   (req_level),
        .l2_en   (req_l2_en),
        .nv      (req_nv),
        .nv2     (req_nv2),
        .hit     (hit),
        .outcome (outcome)
    );

    // Write grants: the main port outranks the alias port.
    always_comb begin
        dir_wr = req_valid && hit && req_write && (outcome == OUT_DIRECT) && L2_ON;
        al_ok  = al_wr_en && (al_level >= LVL_HYP) && L2_ON && !dir_wr;
    end

    tid_gate_store #(
        .DATA_W  (DATA_W),
        .ALIAS_W (ALIAS_W),
        .HAS_L2  (HAS_L2)
    ) u_store (
        .clk        (clk),
        .wr_en      (dir_wr),
        .wr_data    (req_wdata),
        .al_wr_en   (al_ok),
        .al_wr_data (al_wdata),
        .value      (value)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid && hit) begin
            unique case (outcome)
                OUT_UNDEF: rsp_d.undef = 1'b1;
                OUT_TRAP: begin
                    rsp_d.trap = 1'b1;
                    rsp_d.ec   = TRAP_EC;
                end
                OUT_REDIR: begin
                    rsp_d.redir = 1'b1;
                    rsp_d.off   = REDIR_OFF;
                    if (req_write) begin
                        rsp_d.mem_we    = 1'b1;
                        rsp_d.mem_wdata = req_wdata;
                    end else begin
                        rsp_d.rdata = mem_rdata;
                    end
                end
                OUT_DIRECT: begin
                    rsp_d.direct = 1'b1;
                    rsp_d.rdata  = value;
                end
                default: rsp_d.undef = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign al_rdata      = value[ALIAS_W-1:0];
    assign rsp_undef     = rsp_q.undef;
    assign rsp_trap      = rsp_q.trap;
    assign rsp_trap_ec   = rsp_q.ec;
    assign rsp_redir     = rsp_q.redir;
    assign rsp_redir_off = rsp_q.off;
    assign rsp_direct    = rsp_q.direct;
    assign rsp_rdata     = rsp_q.rdata;
    assign rsp_mem_we    = rsp_q.mem_we;
    assign rsp_mem_wdata = rsp_q.mem_wdata;

endmodule

// File: rtl/tid_gate_chk.sv
module tid_gate_chk
    import tid_gate_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                EC_W      = 6,
    parameter int                OFF_W     = 12,
    parameter logic [EC_W-1:0]   TRAP_EC   = 6'h18,
    parameter logic [OFF_W-1:0]  REDIR_OFF = 12'h090,
    parameter int                HAS_L2    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op0,
    input logic [2:0]        req_op1,
    input logic [3:0]        req_crn,
    input logic [3:0]        req_crm,
    input logic [2:0]        req_op2,
    input logic [1:0]        req_level,
    input logic              req_l2_en,
    input logic              req_nv,
    input logic              req_nv2,
    input logic              rsp_undef,
    input logic              rsp_trap,
    input logic [EC_W-1:0]   rsp_trap_ec,
    input logic              rsp_redir,
    input logic [OFF_W-1:0]  rsp_redir_off,
    input logic              rsp_direct,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_mem_we
);
    logic       sel;
    logic [3:0] flags;

    assign sel   = req_valid && ({req_op0, req_op1, req_crn, req_crm, req_op2} == TID_ENC);
    assign flags = {rsp_undef, rsp_trap, rsp_redir, rsp_direct};

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> ($countones(flags) == 1));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (flags == 4'b0000));

    p_nomatch_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel) |=> (flags == 4'b0000));

    p_user_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && req_level == LVL_USER) |=> rsp_undef);

    p_redir_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && HAS_L2 != 0 && req_level == LVL_KERN && req_l2_en && req_nv && req_nv2)
        |=> rsp_redir);

    p_redir_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redir |-> (rsp_redir_off == REDIR_OFF));

    p_mem_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mem_we |-> rsp_redir);

    p_trap_ec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_trap_ec == TRAP_EC));

    p_kern_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && req_level == LVL_KERN && !(req_l2_en && req_nv)) |=> rsp_undef);

    p_mon_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && req_level == LVL_MON) |=> rsp_direct);

    p_absent_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_L2 == 0 && rsp_direct) |-> (rsp_rdata == '0));

endmodule

bind tid_gate tid_gate_chk #(
    .DATA_W    (DATA_W),
    .EC_W      (EC_W),
    .OFF_W     (OFF_W),
    .TRAP_EC   (TRAP_EC),
    .REDIR_OFF (REDIR_OFF),
    .HAS_L2    (HAS_L2)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op0       (req_op0),
    .req_op1       (req_op1),
    .req_crn       (req_crn),
    .req_crm       (req_crm),
    .req_op2       (req_op2),
    .req_level     (req_level),
    .req_l2_en     (req_l2_en),
    .req_nv        (req_nv),
    .req_nv2       (req_nv2),
    .rsp_undef     (rsp_undef),
    .rsp_trap      (rsp_trap),
    .rsp_trap_ec   (rsp_trap_ec),
    .rsp_redir     (rsp_redir),
    .rsp_redir_off (rsp_redir_off),
    .rsp_direct    (rsp_direct),
    .rsp_rdata     (rsp_rdata),
    .rsp_mem_we    (rsp_mem_we)
);

// File: tb/tid_gate_tb.sv
module tid_gate_tb;
    import tid_gate_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    sysenc_t     enc = '0;
    logic [1:0]  req_level = 2'd0;
    logic        req_l2_en = 1'b0;
    logic        req_nv = 1'b0;
    logic        req_nv2 = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] mem_rdata = '0;
    logic        al_wr_en = 1'b0;
    logic [1:0]  al_level = 2'd0;
    logic [31:0] al_wdata = '0;

    logic [31:0] al_rdata,  n_al_rdata;
    logic        rsp_undef, rsp_trap, rsp_redir, rsp_direct, rsp_mem_we;
    logic        n_undef, n_trap, n_redir, n_direct, n_mem_we;
    logic [5:0]  rsp_trap_ec, n_ec;
    logic [11:0] rsp_redir_off, n_off;
    logic [63:0] rsp_rdata, rsp_mem_wdata, n_rdata, n_mem_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tid_gate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(enc.op0), .req_op1(enc.op1), .req_crn(enc.crn), .req_crm(enc.crm),
        .req_op2(enc.op2), .req_level(req_level), .req_l2_en(req_l2_en),
        .req_nv(req_nv), .req_nv2(req_nv2), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .al_wr_en(al_wr_en), .al_level(al_level),
        .al_wdata(al_wdata), .al_rdata(al_rdata), .rsp_undef(rsp_undef),
        .rsp_trap(rsp_trap), .rsp_trap_ec(rsp_trap_ec), .rsp_redir(rsp_redir),
        .rsp_redir_off(rsp_redir_off), .rsp_direct(rsp_direct),
        .rsp_rdata(rsp_rdata), .rsp_mem_we(rsp_mem_we), .rsp_mem_wdata(rsp_mem_wdata)
    );

    tid_gate #(.HAS_L2(0)) u_dut_nol2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(enc.op0), .req_op1(enc.op1), .req_crn(enc.crn), .req_crm(enc.crm),
        .req_op2(enc.op2), .req_level(req_level), .req_l2_en(req_l2_en),
        .req_nv(req_nv), .req_nv2(req_nv2), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .al_wr_en(al_wr_en), .al_level(al_level),
        .al_wdata(al_wdata), .al_rdata(n_al_rdata), .rsp_undef(n_undef),
        .rsp_trap(n_trap), .rsp_trap_ec(n_ec), .rsp_redir(n_redir),
        .rsp_redir_off(n_off), .rsp_direct(n_direct),
        .rsp_rdata(n_rdata), .rsp_mem_we(n_mem_we), .rsp_mem_wdata(n_mem_wdata)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] lvl;
        logic       l2;
        logic       nv;
        logic       nv2;
        logic [3:0] exp; // {undef, trap, redir, direct}
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 4'b1000},
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'b1000},
        '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 4'b0010},
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 4'b0010},
        '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 4'b0100},
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 4'b0100},
        '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 4'b1000},
        '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 4'b1000},
        '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 4'b1000},
        '{1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 4'b0001},
        '{1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 4'b0001},
        '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 4'b1000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic wr, input sysenc_t e, input logic [1:0] lvl,
                        input logic l2, input logic nv, input logic nv2,
                        input logic [63:0] wd, input logic [63:0] mrd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; enc = e; req_level = lvl;
        req_l2_en = l2; req_nv = nv; req_nv2 = nv2; req_wdata = wd; mem_rdata = mrd;
        @(negedge clk);
        req_valid = 1'b0; al_wr_en = 1'b0;
    endtask

    task automatic alias_wr(input logic [1:0] lvl, input logic [31:0] d);
        @(negedge clk);
        al_wr_en = 1'b1; al_level = lvl; al_wdata = d;
        @(negedge clk);
        al_wr_en = 1'b0;
    endtask

    function automatic logic [3:0] flags();
        return {rsp_undef, rsp_trap, rsp_redir, rsp_direct};
    endfunction

    function automatic logic [3:0] nflags();
        return {n_undef, n_trap, n_redir, n_direct};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        sysenc_t bad;
        repeat (3) @(negedge clk);
        check("R7 reset flags", {60'd0, flags()}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle flags", {60'd0, flags()}, 64'd0);

        // R2 R3 R4 R5 R6: outcome table
        for (int i = 0; i < NV; i++) begin
            string tag;
            send(VECS[i].wr, TID_ENC, VECS[i].lvl, VECS[i].l2, VECS[i].nv,
                 VECS[i].nv2, 64'd0, 64'd0);
            if (VECS[i].lvl == 2'd0)           tag = "R2 table";
            else if (VECS[i].exp == 4'b0010)   tag = "R3 table";
            else if (VECS[i].exp == 4'b0100)   tag = "R4 table";
            else if (VECS[i].lvl == 2'd1)      tag = "R5 table";
            else                               tag = "R6 table";
            check(tag, {60'd0, flags()}, {60'd0, VECS[i].exp});
        end

        // R6 / R8: direct write, old value returned
        send(1'b1, TID_ENC, 2'd2, 1'b1, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd0);
        check("R6 direct write flag", {63'd0, rsp_direct}, 64'd1);
        send(1'b1, TID_ENC, 2'd3, 1'b0, 1'b0, 1'b0, 64'hFEDC_BA98_7654_3210, 64'd0);
        check("R8 old value on write", rsp_rdata, 64'h0123_4567_89AB_CDEF);
        @(negedge clk);
        check("R7 single cycle", {60'd0, flags()}, 64'd0);
        send(1'b0, TID_ENC, 2'd2, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R6 direct read", rsp_rdata, 64'hFEDC_BA98_7654_3210);
        check("R9 alias view", {32'd0, al_rdata}, 64'h7654_3210);

        // R3: redirect read and write
        send(1'b0, TID_ENC, 2'd1, 1'b1, 1'b1, 1'b1, 64'd0, 64'h1111_2222_3333_4444);
        check("R3 redirect read data", rsp_rdata, 64'h1111_2222_3333_4444);
        check("R3 redirect offset", {52'd0, rsp_redir_off}, 64'h090);
        check("R3 redirect read no we", {63'd0, rsp_mem_we}, 64'd0);
        send(1'b1, TID_ENC, 2'd1, 1'b1, 1'b1, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0);
        check("R3 redirect we", {63'd0, rsp_mem_we}, 64'd1);
        check("R3 redirect wdata", rsp_mem_wdata, 64'hAAAA_BBBB_CCCC_DDDD);
        send(1'b0, TID_ENC, 2'd3, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R3 register untouched", rsp_rdata, 64'hFEDC_BA98_7654_3210);

        // R4: trap class
        send(1'b0, TID_ENC, 2'd1, 1'b1, 1'b1, 1'b0, 64'd0, 64'd0);
        check("R4 trap class", {58'd0, rsp_trap_ec}, 64'h18);

        // R1: non-matching encodings
        bad = TID_ENC; bad.op2 = 3'b011;
        send(1'b1, bad, 2'd2, 1'b1, 1'b0, 1'b0, 64'h0, 64'd0);
        check("R1 nomatch write flags", {60'd0, flags()}, 64'd0);
        bad = TID_ENC; bad.crn = 4'b1100;
        send(1'b0, bad, 2'd3, 1'b1, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R1 nomatch read flags", {60'd0, flags()}, 64'd0);
        send(1'b0, TID_ENC, 2'd2, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R1 register kept", rsp_rdata, 64'hFEDC_BA98_7654_3210);

        // R9: alias port
        alias_wr(2'd2, 32'hCAFE_F00D);
        check("R9 alias write low", {32'd0, al_rdata}, 64'hCAFE_F00D);
        send(1'b0, TID_ENC, 2'd3, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R9 alias keeps high", rsp_rdata, 64'hFEDC_BA98_CAFE_F00D);
        alias_wr(2'd1, 32'h0000_0000);
        check("R9 alias low level ignored", {32'd0, al_rdata}, 64'hCAFE_F00D);
        al_wr_en = 1'b1; al_level = 2'd3; al_wdata = 32'h9999_9999;
        send(1'b1, TID_ENC, 2'd2, 1'b0, 1'b0, 1'b0, 64'h5555_6666_7777_8888, 64'd0);
        send(1'b0, TID_ENC, 2'd2, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R9 main port wins", rsp_rdata, 64'h5555_6666_7777_8888);

        // R10: variant without level 2
        send(1'b1, TID_ENC, 2'd3, 1'b0, 1'b0, 1'b0, 64'h1234_0000_0000_5678, 64'd0);
        check("R10 write direct flag", {60'd0, nflags()}, 64'b0001);
        send(1'b0, TID_ENC, 2'd3, 1'b1, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R10 read zero", n_rdata, 64'd0);
        check("R10 read direct flag", {60'd0, nflags()}, 64'b0001);
        check("R10 alias zero", {32'd0, n_al_rdata}, 64'd0);
        send(1'b0, TID_ENC, 2'd1, 1'b1, 1'b1, 1'b1, 64'd0, 64'd0);
        check("R10 level1 undef", {60'd0, nflags()}, 64'b1000);
        send(1'b0, TID_ENC, 2'd2, 1'b1, 1'b0, 1'b0, 64'd0, 64'd0);
        check("R10 level2 undef", {60'd0, nflags()}, 64'b1000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule